// File: doc/BRIEF.md
# Frame-Locked Word Pairing Gearbox

This block sits behind a 1:7 deserializer that serves two lanes of a high-speed ADC link: a data lane and a frame lane. Every word clock it receives one 7-bit word from each lane. Two consecutive words make up one 14-bit sample. The first word of the pair is the upper half and the second is the lower half, and bit 6 of each word is the earliest bit on the wire. The frame lane sends a fixed 14-bit shape. When the boundary is right, that shape reads as seven ones followed by seven zeros, so the upper frame word is `1111111` and the lower frame word is `0000000`.

While the frame pair does not show that shape, the block searches for the correct boundary. It sends one-cycle slip requests back to the deserializer, and each request moves the word boundary by one bit. After seven bit positions have failed, it changes which word opens a pair instead of slipping again. This covers all fourteen possible alignments. Once the frame pair matches, the block declares lock, stops slipping and emits one 14-bit sample for every two words. An optional static setting flips the sample MSB, which turns two's complement into offset binary.

The output carries a valid strobe and no ready. The words arrive from a free-running deserializer that cannot stall, so the consumer must accept every sample in the cycle in which valid is high. Back-pressure is not supported.

Top module: `frame_align_gearbox`

## Requirements
- R1: While reset is active and in the first cycle after it, `bitslip`, `locked` and `sample_valid` are low.
- R2: In search, the block evaluates a pair only after a settle period. A frame pair equal to 14'b11111110000000 (upper word all ones, lower word all zeros) sets `locked` and stops slip requests.
- R3: Each slip request is a single-cycle pulse. After a slip or a pairing change, the block waits 4 word clocks before it evaluates again, so two slip pulses are at least 4 idle cycles apart.
- R4: The search covers 7 bit positions under both word pairings. From any starting bit offset, lock is reached within 300 word clocks.
- R5: While `locked` is high, `bitslip` stays low.
- R6: While locked, `sample_valid` is high every second cycle and never in two consecutive cycles. Each valid sample is {upper word, lower word}, with upper word bit 6 at sample bit 13.
- R7: Up to 7 consecutive mismatched frame pairs leave `locked` high. Any matching pair clears the miss count.
- R8: Eight consecutive mismatched frame pairs drop `locked`, stop `sample_valid` and restart the search. The block then locks again once the frame returns.
- R9: With `offset_binary_en` high, sample bit 13 is inverted and bits 12:0 pass through unchanged. With it low, the sample is passed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_word | input | 7 | Parallel word from the data lane, bit 6 earliest |
| frame_word | input | 7 | Parallel word from the frame lane, bit 6 earliest |
| offset_binary_en | input | 1 | Static setting: invert the sample MSB |
| bitslip | output | 1 | One-cycle request to move the word boundary by one bit |
| locked | output | 1 | Frame alignment achieved |
| sample | output | 14 | Assembled 14-bit sample |
| sample_valid | output | 1 | Sample qualifier, one cycle in two while locked |

## Verification
Two of the block's functions can fall in the same cycle. One is the eighth consecutive frame miss, which drops lock. The other is the emission of a sample from that same pair, so the final valid strobe can appear in the cycle where `locked` has already fallen. The bench provokes this by holding the frame lane at zeros for many pair periods while samples are streaming. It then judges that no valid strobe follows the drop and that each valid strobe had lock in the cycle before. A second test corrupts the frame for 12 cycles, which is just short of the miss limit, and confirms that lock survives.

// File: rtl/fag_pkg.sv
package fag_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } align_st_e;
endpackage

// File: rtl/fag_pair.sv
// Word pairing: phase toggles every word clock unless held.
// Phase 0 stores the upper half; phase 1 completes the pair.
module fag_pair #(
  parameter int W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic [W-1:0]   data_in,
  input  logic [W-1:0]   frame_in,
  output logic           pair_done,
  output logic [2*W-1:0] pair_data,
  output logic [2*W-1:0] pair_frame
);
  logic         phase_q;
  logic [W-1:0] up_data_q;
  logic [W-1:0] up_frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= 1'b0;
      up_data_q  <= '0;
      up_frame_q <= '0;
    end else begin
      if (!hold) phase_q <= ~phase_q;
      if (!phase_q) begin
        up_data_q  <= data_in;
        up_frame_q <= frame_in;
      end
    end
  end

  assign pair_done  = phase_q;
  assign pair_data  = {up_data_q, data_in};
  assign pair_frame = {up_frame_q, frame_in};
endmodule

// File: rtl/fag_align.sv
// Boundary search and lock supervision.
module fag_align
  import fag_pkg::*;
#(
  parameter int W          = 7,
  parameter int SETTLE     = 4,
  parameter int MISS_LIMIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pair_done,
  input  logic [2*W-1:0] pair_frame,
  output logic           slip,
  output logic           hold,
  output logic           locked
);
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam int TRY_W  = $clog2(W);
  localparam int MISS_W = $clog2(MISS_LIMIT);
  localparam logic [2*W-1:0] TARGET = {{W{1'b1}}, {W{1'b0}}};

  align_st_e   st_q;
  logic [SET_W-1:0]  settle_q;
  logic [TRY_W-1:0]  try_q;
  logic [MISS_W-1:0] miss_q;
  logic              match;

  assign match  = (pair_frame == TARGET);
  assign locked = (st_q == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_SEARCH;
      settle_q <= '0;
      try_q    <= '0;
      miss_q   <= '0;
      slip     <= 1'b0;
      hold     <= 1'b0;
    end else begin
      slip <= 1'b0;
      hold <= 1'b0;
      if (settle_q != '0) settle_q <= settle_q - 1'b1;
      unique case (st_q)
        ST_SEARCH: begin
          if (pair_done && settle_q == '0) begin
            if (match) begin
              st_q   <= ST_LOCKED;
              miss_q <= '0;
            end else if (try_q == TRY_W'(W - 1)) begin
              hold     <= 1'b1;
              try_q    <= '0;
              settle_q <= SET_W'(SETTLE);
            end else begin
              slip     <= 1'b1;
              try_q    <= try_q + 1'b1;
              settle_q <= SET_W'(SETTLE);
            end
          end
        end
        ST_LOCKED: begin
          if (pair_done) begin
            if (match) begin
              miss_q <= '0;
            end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
              st_q     <= ST_SEARCH;
              miss_q   <= '0;
              try_q    <= '0;
              settle_q <= '0;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_SEARCH;
      endcase
    end
  end
endmodule

// File: rtl/fag_out.sv
// Registered sample stage with optional MSB inversion.
module fag_out #(
  parameter int W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pair_done,
  input  logic           locked,
  input  logic           msb_flip,
  input  logic [2*W-1:0] pair_data,
  output logic [2*W-1:0] sample,
  output logic           valid
);
  localparam int SW = 2 * W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= pair_done && locked;
      if (pair_done && locked)
        sample <= {pair_data[SW-1] ^ msb_flip, pair_data[SW-2:0]};
    end
  end
endmodule

// File: rtl/frame_align_gearbox.sv
module frame_align_gearbox #(
  parameter int W          = 7,
  parameter int SETTLE     = 4,
  parameter int MISS_LIMIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   data_word,
  input  logic [W-1:0]   frame_word,
  input  logic           offset_binary_en,
  output logic           bitslip,
  output logic           locked,
  output logic [2*W-1:0] sample,
  output logic           sample_valid
);
  localparam int SW = 2 * W;

  logic          pair_done;
  logic          hold;
  logic [SW-1:0] pair_data;
  logic [SW-1:0] pair_frame;

  fag_pair #(.W(W)) u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .data_in    (data_word),
    .frame_in   (frame_word),
    .pair_done  (pair_done),
    .pair_data  (pair_data),
    .pair_frame (pair_frame)
  );

  fag_align #(.W(W), .SETTLE(SETTLE), .MISS_LIMIT(MISS_LIMIT)) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_done  (pair_done),
    .pair_frame (pair_frame),
    .slip       (bitslip),
    .hold       (hold),
    .locked     (locked)
  );

  fag_out #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_done (pair_done),
    .locked    (locked),
    .msb_flip  (offset_binary_en),
    .pair_data (pair_data),
    .sample    (sample),
    .valid     (sample_valid)
  );
endmodule

// File: rtl/fag_checker.sv
module fag_checker #(
  parameter int SETTLE = 4
) (
  input logic clk,
  input logic rst_n,
  input logic bitslip,
  input logic locked,
  input logic sample_valid
);
  localparam int GW = $clog2(SETTLE + 1);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= GW'(SETTLE);
    else if (bitslip) gap_q <= '0;
    else if (gap_q != GW'(SETTLE)) gap_q <= gap_q + 1'b1;
  end

  assert_slip_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bitslip |=> !bitslip);

  assert_slip_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bitslip |-> (gap_q == GW'(SETTLE)));

  assert_no_slip_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !bitslip);

  assert_valid_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_valid_after_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(locked));
endmodule

bind frame_align_gearbox fag_checker #(.SETTLE(SETTLE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bitslip      (bitslip),
  .locked       (locked),
  .sample_valid (sample_valid)
);

// File: tb/frame_align_gearbox_test.sv
`timescale 1ns/1ps
module frame_align_gearbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  data_word = '0;
  logic [6:0]  frame_word = '0;
  logic        offset_binary_en = 1'b0;
  logic        bitslip, locked, sample_valid;
  logic [13:0] sample;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint k = 0;
  longint base = 0;
  int rot = 0;
  bit corrupt = 0;
  int gap = 100;

  frame_align_gearbox uut (
    .clk(clk), .rst_n(rst_n), .data_word(data_word), .frame_word(frame_word),
    .offset_binary_en(offset_binary_en), .bitslip(bitslip), .locked(locked),
    .sample(sample), .sample_valid(sample_valid)
  );

  always #2.5 clk = ~clk;

  function automatic logic fbit(longint idx);
    return (idx % 14) < 7;
  endfunction

  function automatic logic dbit(longint idx);
    logic [6:0]  n;
    logic [13:0] s;
    n = 7'((idx / 14) % 128);
    s = {n, ~n};
    return s[13 - int'(idx % 14)];
  endfunction

  // Behavioural deserializer: slip rotates the boundary by one bit, modulo 7.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bitslip) rot = (rot + 1) % 7;
    #1;
    k = k + 1;
    for (int j = 0; j < 7; j++) begin
      data_word[6-j]  = dbit(7 * k + rot + base + j);
      frame_word[6-j] = corrupt ? 1'b0 : fbit(7 * k + rot + base + j);
    end
  end

  // R3 monitor: slip pulses single and at least 4 idle cycles apart.
  always @(negedge clk) begin
    if (rst_n) begin
      if (bitslip) begin
        checks++;
        if (gap < 4) begin
          errors++;
          $display("FAIL R3 slip spacing: actual %0d expected >= 4", gap);
        end
        gap = 0;
      end else if (gap < 100) gap++;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic do_reset(longint b);
    rst_n = 1'b0;
    base = b;
    rot = 0;
    repeat (3) @(negedge clk);
    check(!bitslip && !locked && !sample_valid, "R1 outputs in reset",
          {bitslip, locked, sample_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bitslip && !locked && !sample_valid, "R1 first cycle after reset",
          {bitslip, locked, sample_valid}, 0);
  endtask

  task automatic wait_lock(string req, int limit);
    int n = 0;
    while (!locked && n < limit) begin
      @(negedge clk);
      n++;
    end
    check(locked, req, n, limit);
  endtask

  task automatic check_samples(int count, bit flip);
    logic [13:0] v;
    logic [6:0]  prev = '0;
    bit first = 1;
    int got = 0;
    while (got < count) begin
      @(negedge clk);
      if (sample_valid) begin
        v = flip ? (sample ^ 14'h2000) : sample;
        check(v[6:0] == ~v[13:7], flip ? "R9 msb inverted" : "R6 halves paired",
              sample, {v[13:7], ~v[13:7]});
        if (!first) check(v[13:7] == 7'(prev + 1), "R6 sample order", v[13:7], 7'(prev + 1));
        prev = v[13:7];
        first = 0;
        got++;
      end
    end
  endtask

  task automatic test_acquire(longint b);
    int slips = 0;
    int vcnt = 0;
    do_reset(b);
    wait_lock("R4 lock within bound", 300);
    check_samples(8, 0);
    repeat (60) begin
      @(negedge clk);
      if (bitslip) slips++;
      if (sample_valid) vcnt++;
    end
    check(slips == 0, "R2/R5 no slip while locked", slips, 0);
    check(locked, "R2 lock held on matching frame", locked, 1);
    check(vcnt == 30, "R6 valid one cycle in two", vcnt, 30);
  endtask

  task automatic test_glitch();
    corrupt = 1;
    repeat (12) @(negedge clk);
    corrupt = 0;
    check(locked, "R7 lock holds over short miss run", locked, 1);
    repeat (4) @(negedge clk);
    corrupt = 1;
    repeat (12) @(negedge clk);
    corrupt = 0;
    check(locked, "R7 miss count cleared by good pair", locked, 1);
    repeat (4) @(negedge clk);
    check_samples(6, 0);
  endtask

  task automatic test_loss();
    int late_valid = 0;
    corrupt = 1;
    repeat (24) @(negedge clk);
    check(!locked, "R8 lock dropped after 8 misses", locked, 0);
    repeat (10) begin
      @(negedge clk);
      if (sample_valid) late_valid++;
    end
    check(late_valid == 0, "R8 no samples after drop", late_valid, 0);
    corrupt = 0;
    wait_lock("R8 relock after frame returns", 300);
    check_samples(6, 0);
  endtask

  task automatic test_offset_binary();
    offset_binary_en = 1'b1;
    repeat (2) @(negedge clk);
    check_samples(8, 1);
    offset_binary_en = 1'b0;
    repeat (2) @(negedge clk);
    check_samples(4, 0);
  endtask

  initial begin
    test_acquire(0);
    test_acquire(3);
    test_acquire(7);
    test_acquire(11);
    test_acquire(13);
    test_glitch();
    test_loss();
    test_offset_binary();
    finish_run();
  end
endmodule